// File: doc/BRIEF.md
# Dual-Channel Host Register Bus Decoder

This block sits between an 8-bit asynchronous host bus and the register files of two identical serial channels, called A and B. The host drives an active-low chip select, a channel-select level, a 3-bit register index and separate active-low read and write strobes. The block brings the chip select and both strobes into the internal clock domain. It turns each completed write into one single-cycle write strobe toward the addressed channel, and each started read into one single-cycle read strobe. While a read is in progress it returns the addressed byte on the host data bus under a tristate enable.

Each channel owns one bit of state held inside this block: a broadcast flag, stored in bit 0 of the register at index `MODE_IDX`, default 7. While either channel's flag is set, every host write with chip select low reaches the same register index in both channels in the same clock cycle. Reads keep following the channel-select input.

The block also passes each channel's interrupt request and transmitter-ready level to dedicated outputs through one register stage.

Top module: `hbus_dual_decoder`

## Requirements
- R1: While `hb_cs_n` is high, a strobe on `hb_wr_n` or `hb_rd_n` produces no channel write or read strobe, and `hb_oe` stays low.
- R2: With `hb_cs_n` low, `hb_chan_sel` = 1 targets channel A and `hb_chan_sel` = 0 targets channel B. This holds for both writes and reads while broadcast is off.
- R3: Each low-to-high transition of `hb_wr_n` with `hb_cs_n` low yields exactly one single-cycle write strobe per targeted channel. `ch_waddr` and `ch_wdata` carry `hb_addr` and `hb_din` in that cycle.
- R4: `hb_oe` is high only while `hb_cs_n` and `hb_rd_n` are both low. During that time `hb_dout` holds the addressed byte of the selected channel. Each high-to-low transition of `hb_rd_n` with `hb_cs_n` low yields exactly one single-cycle read strobe.
- R5: Bit 0 of a write to index `MODE_IDX` (default 7) sets or clears the broadcast flag of every channel that write reaches. A read of that index returns the flag of the selected channel in bit 0, with bits 7..1 equal to 0.
- R6: While either channel's broadcast flag is 1, a write with `hb_cs_n` low produces write strobes to both channels in the same clock cycle, regardless of `hb_chan_sel`.
- R7: While broadcast is on, reads, read strobes and `hb_dout` follow `hb_chan_sel` alone.
- R8: After reset, both broadcast flags read back as 0.
- R9: `irq_a`/`irq_b` (active high) and `txrdy_a_n`/`txrdy_b_n` (active low) follow their channel inputs one clock later. After reset they sit at 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_chan_sel | input | 1 | Channel select: 1 = A, 0 = B |
| hb_addr | input | 3 | Register index |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_rd_n | input | 1 | Host read strobe, active low |
| hb_din | input | 8 | Host write data |
| hb_dout | output | 8 | Host read data |
| hb_oe | output | 1 | Tristate enable for hb_dout |
| ch_addr | output | 3 | Register index for channel read data |
| ch_waddr | output | 3 | Register index of the write strobe |
| ch_wdata | output | 8 | Data of the write strobe |
| cha_wr_stb | output | 1 | Channel A write strobe |
| cha_rd_stb | output | 1 | Channel A read strobe |
| cha_rdata | input | 8 | Channel A register read data |
| chb_wr_stb | output | 1 | Channel B write strobe |
| chb_rd_stb | output | 1 | Channel B read strobe |
| chb_rdata | input | 8 | Channel B register read data |
| cha_irq | input | 1 | Channel A service request |
| chb_irq | input | 1 | Channel B service request |
| cha_txrdy_n | input | 1 | Channel A transmitter ready, active low |
| chb_txrdy_n | input | 1 | Channel B transmitter ready, active low |
| irq_a | output | 1 | Channel A interrupt, active high |
| irq_b | output | 1 | Channel B interrupt, active high |
| txrdy_a_n | output | 1 | Channel A transmitter ready, active low |
| txrdy_b_n | output | 1 | Channel B transmitter ready, active low |

## Verification
Two functions share one clock cycle. The first is the dual-channel write strobe. The second is the update of the broadcast flags when that same write targets the mode register index, which changes the routing for every later write. The random stream writes random bytes to index 7 often, so broadcast turns on and off many times, sometimes from a write with channel select pointing at the other channel. The bench counts the strobes each channel receives per transaction and compares the count against a model that uses the flags as they stood before the write. The next read of index 7 or of a data register then shows whether each channel saw the intended write.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  localparam int unsigned HBD_NCH = 2;
  typedef enum logic {
    CH_B = 1'b0,
    CH_A = 1'b1
  } hbd_chan_e;
endpackage

// File: rtl/hbd_sync.sv
// Two-flop level synchronizer with a selectable reset level.
module hbd_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/hbd_edge.sv
// Edge detection on the synchronized host strobes, gated by chip select.
module hbd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s_n,
  input  logic wr_s_n,
  input  logic rd_s_n,
  output logic wr_done,
  output logic rd_start
);
  logic wr_d_q, rd_d_q;
  logic wr_d_nx, rd_d_nx;

  always_comb begin
    wr_d_nx = wr_s_n;
    rd_d_nx = rd_s_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d_q <= 1'b1;
      rd_d_q <= 1'b1;
    end else begin
      wr_d_q <= wr_d_nx;
      rd_d_q <= rd_d_nx;
    end
  end

  // Write completes on the rising strobe edge; read starts on the falling one.
  assign wr_done  = !cs_s_n &&  wr_s_n && !wr_d_q;
  assign rd_start = !cs_s_n && !rd_s_n &&  rd_d_q;
endmodule

// File: rtl/hbd_chan_port.sv
// Per-channel strobe generation, broadcast flag and status registers.
module hbd_chan_port #(
  parameter int unsigned       AW       = 3,
  parameter logic [AW-1:0]     MODE_IDX = '1,
  parameter hbd_pkg::hbd_chan_e CH_ID   = hbd_pkg::CH_B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_done,
  input  logic          rd_start,
  input  logic          chan_sel,
  input  logic          bcast,
  input  logic [AW-1:0] addr,
  input  logic          din_lsb,
  input  logic          irq_in,
  input  logic          txrdy_n_in,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic          mode,
  output logic          irq_out,
  output logic          txrdy_n_out
);
  logic picked;
  logic wr_stb_q, rd_stb_q, mode_q, irq_q, txrdy_n_q;
  logic wr_stb_nx, rd_stb_nx, mode_nx;
  logic mode_en;

  assign picked = (chan_sel == logic'(CH_ID));

  always_comb begin
    wr_stb_nx = wr_done && (picked || bcast);
    rd_stb_nx = rd_start && picked;
    mode_en   = wr_stb_nx && (addr == MODE_IDX);
    mode_nx   = mode_en ? din_lsb : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_q  <= 1'b0;
      rd_stb_q  <= 1'b0;
      mode_q    <= 1'b0;
      irq_q     <= 1'b0;
      txrdy_n_q <= 1'b1;
    end else begin
      wr_stb_q  <= wr_stb_nx;
      rd_stb_q  <= rd_stb_nx;
      if (mode_en) begin
        mode_q <= mode_nx;
      end
      irq_q     <= irq_in;
      txrdy_n_q <= txrdy_n_in;
    end
  end

  assign wr_stb      = wr_stb_q;
  assign rd_stb      = rd_stb_q;
  assign mode        = mode_q;
  assign irq_out     = irq_q;
  assign txrdy_n_out = txrdy_n_q;
endmodule

// File: rtl/hbus_dual_decoder.sv
module hbus_dual_decoder #(
  parameter int unsigned   AW       = 3,
  parameter int unsigned   DW       = 8,
  parameter logic [AW-1:0] MODE_IDX = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_cs_n,
  input  logic          hb_chan_sel,
  input  logic [AW-1:0] hb_addr,
  input  logic          hb_wr_n,
  input  logic          hb_rd_n,
  input  logic [DW-1:0] hb_din,
  output logic [DW-1:0] hb_dout,
  output logic          hb_oe,
  output logic [AW-1:0] ch_addr,
  output logic [AW-1:0] ch_waddr,
  output logic [DW-1:0] ch_wdata,
  output logic          cha_wr_stb,
  output logic          cha_rd_stb,
  input  logic [DW-1:0] cha_rdata,
  output logic          chb_wr_stb,
  output logic          chb_rd_stb,
  input  logic [DW-1:0] chb_rdata,
  input  logic          cha_irq,
  input  logic          chb_irq,
  input  logic          cha_txrdy_n,
  input  logic          chb_txrdy_n,
  output logic          irq_a,
  output logic          irq_b,
  output logic          txrdy_a_n,
  output logic          txrdy_b_n
);
  import hbd_pkg::*;
  localparam int unsigned NCH = HBD_NCH;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_m_q, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_sn  <= rst_m_q;
    end
  end

  // Strobes and chip select into the clock domain.
  logic [2:0] ctl_s;
  hbd_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({hb_cs_n, hb_wr_n, hb_rd_n}),
    .q     (ctl_s)
  );

  logic wr_done, rd_start;
  hbd_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_sn),
    .cs_s_n   (ctl_s[2]),
    .wr_s_n   (ctl_s[1]),
    .rd_s_n   (ctl_s[0]),
    .wr_done  (wr_done),
    .rd_start (rd_start)
  );

  // Per-channel slices; index 1 is channel A, index 0 is channel B.
  logic [NCH-1:0] mode_q;
  logic [NCH-1:0] wr_stb, rd_stb, irq_in, irq_out, txn_in, txn_out;
  logic           bcast;

  assign bcast  = |mode_q;
  assign irq_in = {cha_irq, chb_irq};
  assign txn_in = {cha_txrdy_n, chb_txrdy_n};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    hbd_chan_port #(
      .AW       (AW),
      .MODE_IDX (MODE_IDX),
      .CH_ID    ((g == 1) ? CH_A : CH_B)
    ) u_port (
      .clk         (clk),
      .rst_n       (rst_sn),
      .wr_done     (wr_done),
      .rd_start    (rd_start),
      .chan_sel    (hb_chan_sel),
      .bcast       (bcast),
      .addr        (hb_addr),
      .din_lsb     (hb_din[0]),
      .irq_in      (irq_in[g]),
      .txrdy_n_in  (txn_in[g]),
      .wr_stb      (wr_stb[g]),
      .rd_stb      (rd_stb[g]),
      .mode        (mode_q[g]),
      .irq_out     (irq_out[g]),
      .txrdy_n_out (txn_out[g])
    );
  end

  // Write address/data captured alongside the write strobes.
  logic [AW-1:0] waddr_q, waddr_nx;
  logic [DW-1:0] wdata_q, wdata_nx;

  always_comb begin
    waddr_nx = hb_addr;
    wdata_nx = hb_din;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (wr_done) begin
      waddr_q <= waddr_nx;
      wdata_q <= wdata_nx;
    end
  end

  // Read path is combinational so data is valid for the whole strobe.
  logic [DW-1:0] sel_rdata;
  always_comb begin
    sel_rdata = hb_chan_sel ? cha_rdata : chb_rdata;
    if (hb_addr == MODE_IDX) begin
      sel_rdata = {{(DW-1){1'b0}}, mode_q[hb_chan_sel]};
    end
  end

  assign hb_dout    = sel_rdata;
  assign hb_oe      = !hb_cs_n && !hb_rd_n;
  assign ch_addr    = hb_addr;
  assign ch_waddr   = waddr_q;
  assign ch_wdata   = wdata_q;
  assign cha_wr_stb = wr_stb[1];
  assign chb_wr_stb = wr_stb[0];
  assign cha_rd_stb = rd_stb[1];
  assign chb_rd_stb = rd_stb[0];
  assign irq_a      = irq_out[1];
  assign irq_b      = irq_out[0];
  assign txrdy_a_n  = txn_out[1];
  assign txrdy_b_n  = txn_out[0];
endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic       clk,
  input logic       rst_sn,
  input logic       hb_cs_n,
  input logic       hb_oe,
  input logic       cha_wr_stb,
  input logic       chb_wr_stb,
  input logic       cha_rd_stb,
  input logic       chb_rd_stb,
  input logic [1:0] mode_q,
  input logic       cha_irq,
  input logic       irq_a,
  input logic       chb_txrdy_n,
  input logic       txrdy_b_n
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_no_oe_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    hb_cs_n |-> !hb_oe);

  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (cha_wr_stb || chb_wr_stb) |=> !(cha_wr_stb || chb_wr_stb));

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (cha_rd_stb || chb_rd_stb) |=> !(cha_rd_stb || chb_rd_stb));

  assert_flag_by_write_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (past_ok && (mode_q[1] != $past(mode_q[1]))) |-> cha_wr_stb);

  assert_dual_only_bcast_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (past_ok && cha_wr_stb && chb_wr_stb) |-> ($past(mode_q) != 2'b00));

  assert_rd_single_chan_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !(cha_rd_stb && chb_rd_stb));

  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok |-> (irq_a == $past(cha_irq)));

  assert_txrdy_follow_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    past_ok |-> (txrdy_b_n == $past(chb_txrdy_n)));
endmodule

bind hbus_dual_decoder hbd_checker u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .hb_cs_n     (hb_cs_n),
  .hb_oe       (hb_oe),
  .cha_wr_stb  (cha_wr_stb),
  .chb_wr_stb  (chb_wr_stb),
  .cha_rd_stb  (cha_rd_stb),
  .chb_rd_stb  (chb_rd_stb),
  .mode_q      (mode_q),
  .cha_irq     (cha_irq),
  .irq_a       (irq_a),
  .chb_txrdy_n (chb_txrdy_n),
  .txrdy_b_n   (txrdy_b_n)
);

// File: tb/hbus_dual_decoder_tb.sv
module hbus_dual_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic hb_cs_n, hb_chan_sel, hb_wr_n, hb_rd_n;
  logic [2:0] hb_addr;
  logic [7:0] hb_din, hb_dout;
  logic hb_oe;
  logic [2:0] ch_addr, ch_waddr;
  logic [7:0] ch_wdata, cha_rdata, chb_rdata;
  logic cha_wr_stb, cha_rd_stb, chb_wr_stb, chb_rd_stb;
  logic cha_irq, chb_irq, cha_txrdy_n, chb_txrdy_n;
  logic irq_a, irq_b, txrdy_a_n, txrdy_b_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbus_dual_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .hb_cs_n(hb_cs_n), .hb_chan_sel(hb_chan_sel),
    .hb_addr(hb_addr), .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n), .hb_din(hb_din),
    .hb_dout(hb_dout), .hb_oe(hb_oe), .ch_addr(ch_addr), .ch_waddr(ch_waddr),
    .ch_wdata(ch_wdata), .cha_wr_stb(cha_wr_stb), .cha_rd_stb(cha_rd_stb),
    .cha_rdata(cha_rdata), .chb_wr_stb(chb_wr_stb), .chb_rd_stb(chb_rd_stb),
    .chb_rdata(chb_rdata), .cha_irq(cha_irq), .chb_irq(chb_irq),
    .cha_txrdy_n(cha_txrdy_n), .chb_txrdy_n(chb_txrdy_n), .irq_a(irq_a),
    .irq_b(irq_b), .txrdy_a_n(txrdy_a_n), .txrdy_b_n(txrdy_b_n)
  );

  // Channel register-file stubs.
  logic [7:0] rf_a [8];
  logic [7:0] rf_b [8];
  int cnt_wa, cnt_wb, cnt_ra, cnt_rb;
  assign cha_rdata = rf_a[ch_addr];
  assign chb_rdata = rf_b[ch_addr];

  always @(posedge clk) begin
    if (cha_wr_stb) begin rf_a[ch_waddr] <= ch_wdata; cnt_wa <= cnt_wa + 1; end
    if (chb_wr_stb) begin rf_b[ch_waddr] <= ch_wdata; cnt_wb <= cnt_wb + 1; end
    if (cha_rd_stb) cnt_ra <= cnt_ra + 1;
    if (chb_rd_stb) cnt_rb <= cnt_rb + 1;
  end

  // Bench model.
  logic [7:0] m_a [8];
  logic [7:0] m_b [8];
  logic md_a, md_b;
  int n_chk, n_bad;
  bit done;

  function automatic bit hit_wr(bit cs_n, bit sel, bit chan);
    return !cs_n && ((sel == chan) || md_a || md_b);
  endfunction

  function automatic logic [7:0] exp_rd(bit sel, logic [2:0] a);
    if (a == 3'd7) return {7'b0, sel ? md_a : md_b};
    return sel ? m_a[a] : m_b[a];
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(bit cs_n, bit sel, logic [2:0] a, logic [7:0] d);
    bit ha, hb;
    ha = hit_wr(cs_n, sel, 1'b1);
    hb = hit_wr(cs_n, sel, 1'b0);
    @(negedge clk);
    cnt_wa = 0; cnt_wb = 0;
    hb_cs_n = cs_n; hb_chan_sel = sel; hb_addr = a; hb_din = d;
    wait_n(2); hb_wr_n = 1'b0;
    wait_n(4); hb_wr_n = 1'b1;
    wait_n(5); hb_cs_n = 1'b1;
    wait_n(3);
    // R3 one strobe per targeted channel; R1 none with cs high; R6 both in broadcast
    check(cs_n ? "R1" : ((md_a || md_b) ? "R6" : "R3"), cnt_wa, int'(ha));
    check(cs_n ? "R1" : ((md_a || md_b) ? "R6" : "R2"), cnt_wb, int'(hb));
    if (ha) begin m_a[a] = d; if (a == 3'd7) md_a = d[0]; end
    if (hb) begin m_b[a] = d; if (a == 3'd7) md_b = d[0]; end
  endtask

  task automatic host_read(bit cs_n, bit sel, logic [2:0] a);
    string rq;
    rq = (a == 3'd7) ? "R5" : ((md_a || md_b) ? "R7" : "R4");
    @(negedge clk);
    cnt_ra = 0; cnt_rb = 0;
    hb_cs_n = cs_n; hb_chan_sel = sel; hb_addr = a;
    wait_n(2); hb_rd_n = 1'b0;
    wait_n(4);
    check(cs_n ? "R1" : "R4", int'(hb_oe), int'(!cs_n));
    if (!cs_n) check(rq, int'(hb_dout), int'(exp_rd(sel, a)));
    hb_rd_n = 1'b1;
    wait_n(1);
    check("R4", int'(hb_oe), 0);
    wait_n(3); hb_cs_n = 1'b1;
    wait_n(3);
    check(cs_n ? "R1" : "R7", cnt_ra, int'(!cs_n && sel));
    check(cs_n ? "R1" : "R2", cnt_rb, int'(!cs_n && !sel));
  endtask

  task automatic status_step(bit ia, bit ib, bit ta, bit tb);
    @(negedge clk);
    cha_irq = ia; chb_irq = ib; cha_txrdy_n = ta; chb_txrdy_n = tb;
    @(negedge clk);
    check("R9", int'({irq_a, irq_b, txrdy_a_n, txrdy_b_n}), int'({ia, ib, ta, tb}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int seed_dummy;
    n_chk = 0; n_bad = 0; done = 1'b0;
    cnt_wa = 0; cnt_wb = 0; cnt_ra = 0; cnt_rb = 0;
    for (int i = 0; i < 8; i++) begin
      rf_a[i] = 8'h00; rf_b[i] = 8'h00; m_a[i] = 8'h00; m_b[i] = 8'h00;
    end
    md_a = 1'b0; md_b = 1'b0;
    hb_cs_n = 1'b1; hb_chan_sel = 1'b0; hb_addr = '0; hb_wr_n = 1'b1;
    hb_rd_n = 1'b1; hb_din = '0;
    cha_irq = 1'b0; chb_irq = 1'b0; cha_txrdy_n = 1'b1; chb_txrdy_n = 1'b1;
    seed_dummy = $urandom(32'h5eed);
    rst_n = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);

    // Reset state: R9 levels and R8 flags cleared.
    check("R9", int'({irq_a, irq_b, txrdy_a_n, txrdy_b_n}), 4'b0011);
    check("R1", int'(hb_oe), 0);
    host_read(1'b0, 1'b1, 3'd7);  // R8 channel A flag
    host_read(1'b0, 1'b0, 3'd7);  // R8 channel B flag

    // Directed: chip select high ignored (R1), then routing (R2).
    host_write(1'b1, 1'b1, 3'd7, 8'h01);
    host_read(1'b0, 1'b1, 3'd7);
    host_write(1'b0, 1'b1, 3'd2, 8'h11);
    host_write(1'b0, 1'b0, 3'd2, 8'h22);
    host_read(1'b0, 1'b1, 3'd2);
    host_read(1'b0, 1'b0, 3'd2);

    // Broadcast on through channel A (R5, R6), reads still split (R7).
    host_write(1'b0, 1'b1, 3'd7, 8'h01);
    host_read(1'b0, 1'b0, 3'd7);
    host_read(1'b0, 1'b1, 3'd2);
    host_read(1'b0, 1'b0, 3'd2);
    host_write(1'b0, 1'b0, 3'd4, 8'h5a);
    host_read(1'b0, 1'b1, 3'd4);
    host_read(1'b0, 1'b0, 3'd4);
    // Broadcast off from channel B side reaches both flags.
    host_write(1'b0, 1'b0, 3'd7, 8'hfe);
    host_read(1'b0, 1'b1, 3'd7);
    host_write(1'b0, 1'b0, 3'd4, 8'hc3);
    host_read(1'b0, 1'b1, 3'd4);

    status_step(1'b1, 1'b0, 1'b0, 1'b1);
    status_step(1'b0, 1'b1, 1'b1, 1'b0);

    // Constrained random mix.
    for (int n = 0; n < 400; n++) begin
      int op;
      bit cs_n, sel;
      logic [2:0] a;
      op   = int'($urandom % 8);
      cs_n = (($urandom % 8) == 0);
      sel  = 1'($urandom);
      a    = 3'($urandom);
      if (op < 4)      host_write(cs_n, sel, a, 8'($urandom));
      else if (op < 7) host_read(cs_n, sel, a);
      else status_step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // Final sweep of both register files.
    for (int k = 0; k < 8; k++) begin
      host_read(1'b0, 1'b1, 3'(k));
      host_read(1'b0, 1'b0, 3'(k));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule